// File: doc/BRIEF.md
# Register-Pair Double Word Load/Store Sequencer

This block moves a 64-bit value between an even/odd pair of general registers and memory. It does the move as two 32-bit word transactions on a simple request/acknowledge memory port. A command carries the direction (load or store), a 32-bit base value, a 16-bit signed displacement and the even register number of the pair. The sequencer computes a word-aligned effective address and issues the two word accesses one after the other. For a store it reads the pair through a register-file read port. For a load it writes the pair through a register-file write port. It then raises a one-cycle completion pulse.

The odd register of the pair (number + 1) always maps to the effective address, and the even register maps to the effective address + 4. A load reads the low word first and a store writes the high word first. An odd register number is refused with a one-cycle illegal pulse and causes no memory traffic. While a load is in flight, and during the single delay-slot cycle that follows completion, a pending flag names the pair so that a consumer can hold off reading it.

The controller is a five-state machine:
- `ST_IDLE`: waiting for a command.
- `ST_ACC0`: first word access.
- `ST_ACC1`: second word access.
- `ST_DONE`: completion and load-delay slot.
- `ST_FAULT`: illegal operand.

Its transitions are:
- accept: `ST_IDLE`→`ST_ACC0` on a valid command with an even register.
- reject: `ST_IDLE`→`ST_FAULT` on a valid command with an odd register.
- first-ack: `ST_ACC0`→`ST_ACC1`.
- second-ack: `ST_ACC1`→`ST_DONE`.
- retire: `ST_DONE`→`ST_IDLE`.
- clear: `ST_FAULT`→`ST_IDLE`.

Top module: `dw_pair_seq`

## Requirements
- R1: Every memory address is derived from EA = (base + sign-extended 16-bit displacement) with bits 1:0 forced to zero; the two accesses use EA and EA+4 (modulo 2^32).
- R2: A load (cmd_store=0) reads EA first and writes that word to register rt+1, then reads EA+4 and writes that word to register rt; each register write occurs in the cycle the corresponding acknowledge is sampled, with rf_wr_data equal to mem_rdata.
- R3: A store (cmd_store=1) writes register rt to EA+4 first, then register rt+1 to EA, with mem_we=1 on both accesses.
- R4: mem_req stays high with an unchanged mem_addr until mem_ack is sampled; the second access begins only after the first has been acknowledged.
- R5: A command whose register number has bit 0 set produces a one-cycle illegal pulse in the cycle after acceptance and causes no memory request and no register write.
- R6: done is high for exactly one cycle, the cycle right after the second acknowledge, and at no other time.
- R7: cmd_ready is high only when the sequencer is idle; a cmd_valid presented while cmd_ready is low is ignored and generates no access.
- R8: ld_pend is high for a load from the cycle after acceptance through the done cycle inclusive, with ld_pend_reg equal to the even register number; it is never high for a store or an illegal command.
- R9: After reset, cmd_ready=1 and mem_req, rf_wr_en, done, illegal and ld_pend are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_store | input | 1 | 1 = store pair to memory, 0 = load pair |
| cmd_base | input | 32 | Base address value |
| cmd_disp | input | 16 | Signed displacement |
| cmd_reg | input | 5 | Even register number of the pair |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete (one-cycle pulse) |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rf_rd_idx | output | 5 | Register-file read index for stores |
| rf_rd_data | input | 32 | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle odd-register pulse |
| ld_pend | output | 1 | Load pair not yet usable |
| ld_pend_reg | output | 5 | Even register of the pending pair |

## Verification
The assertions assume a well-behaved memory and register file:
- mem_ack arrives only while mem_req is high.
- mem_ack lasts a single cycle per access.
- rf_rd_data follows rf_rd_idx within the same cycle.

The bench's memory model enforces the first two. It counts down a chosen latency only while a request is pending, raises the acknowledge for one cycle, and then drops it before looking at the next request. Commands are driven between clock edges. Some are deliberately presented while the sequencer is busy, to show that they are ignored.

// File: rtl/dw_seq_pkg.sv
package dw_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACC0  = 3'd1,
        ST_ACC1  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } seq_state_e;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } xfer_dir_e;

    // Decoded view of the current state, produced by the FSM output process.
    typedef struct packed {
        logic idle;
        logic access;
        logic phase;   // 0 = first word, 1 = second word
        logic fin;
        logic fault;
    } seq_flags_t;

endpackage

// File: rtl/dw_ea_gen.sv
module dw_ea_gen #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  disp,
    output logic [ADDR_W-1:0] ea_lo,
    output logic [ADDR_W-1:0] ea_hi
);
    localparam int EXT_W = ADDR_W - OFF_W;
    localparam int STEP  = 1 << ALIGN_BITS;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] raw_sum;

    assign disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
    assign raw_sum  = base + disp_ext;

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign ea_lo = {raw_sum[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end else begin : g_noalign
            assign ea_lo = raw_sum;
        end
    endgenerate

    assign ea_hi = ea_lo + ADDR_W'(STEP);

endmodule

// File: rtl/dw_phase_mux.sv
module dw_phase_mux #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 5
) (
    input  dw_seq_pkg::xfer_dir_e dir,
    input  logic                  phase,
    input  logic [REG_W-1:0]      pair_reg,
    input  logic [ADDR_W-1:0]     ea_lo,
    input  logic [ADDR_W-1:0]     ea_hi,
    output logic [ADDR_W-1:0]     acc_addr,
    output logic [REG_W-1:0]      acc_reg
);
    import dw_seq_pkg::*;

    logic [REG_W-1:0] odd_reg;
    logic             low_word;

    assign odd_reg = {pair_reg[REG_W-1:1], 1'b1};

    // Load walks low word then high word; store walks high then low.
    always_comb begin
        low_word = (dir == DIR_LOAD) ? ~phase : phase;
        acc_addr = low_word ? ea_lo : ea_hi;
        acc_reg  = low_word ? odd_reg : pair_reg;
    end

endmodule

// File: rtl/dw_seq_fsm.sv
module dw_seq_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_odd,
    input  logic                   mem_ack,
    output dw_seq_pkg::seq_flags_t flags,
    output logic                   accept
);
    import dw_seq_pkg::*;

    seq_state_e state, state_nx;

    assign accept = cmd_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = cmd_odd ? ST_FAULT : ST_ACC0; // reject / accept
            ST_ACC0:  if (mem_ack) state_nx = ST_ACC1;                    // first-ack
            ST_ACC1:  if (mem_ack) state_nx = ST_DONE;                    // second-ack
            ST_DONE:  state_nx = ST_IDLE;                                 // retire
            ST_FAULT: state_nx = ST_IDLE;                                 // clear
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        flags = '0;
        unique case (state)
            ST_IDLE:  flags.idle = 1'b1;
            ST_ACC0:  flags.access = 1'b1;
            ST_ACC1:  begin flags.access = 1'b1; flags.phase = 1'b1; end
            ST_DONE:  flags.fin = 1'b1;
            ST_FAULT: flags.fault = 1'b1;
            default:  flags = '0;
        endcase
    end

    // R6: completion lasts a single cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags.fin |=> !flags.fin);
    // R6: completion only follows an acknowledged second access
    p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.fin) |-> $past(mem_ack));
    // R5: fault state leaves immediately
    p_fault_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags.fault |=> flags.idle);

endmodule

// File: rtl/dw_pair_seq.sv
module dw_pair_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [OFF_W-1:0]  cmd_disp,
    input  logic [REG_W-1:0]  cmd_reg,
    output logic              cmd_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [REG_W-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [REG_W-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              done,
    output logic              illegal,
    output logic              ld_pend,
    output logic [REG_W-1:0]  ld_pend_reg
);
    import dw_seq_pkg::*;

    localparam int ALIGN_BITS = $clog2(DATA_W / 8);

    seq_flags_t        flags;
    logic              accept;
    logic [ADDR_W-1:0] ea_lo_c, ea_hi_c;
    logic [ADDR_W-1:0] ea_lo_q, ea_hi_q;
    xfer_dir_e         dir_q;
    logic [REG_W-1:0]  reg_q;
    logic [REG_W-1:0]  acc_reg;

    dw_ea_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_BITS(ALIGN_BITS)) u_ea (
        .base  (cmd_base),
        .disp  (cmd_disp),
        .ea_lo (ea_lo_c),
        .ea_hi (ea_hi_c)
    );

    dw_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_odd   (cmd_reg[0]),
        .mem_ack   (mem_ack),
        .flags     (flags),
        .accept    (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_lo_q <= '0;
            ea_hi_q <= '0;
            dir_q   <= DIR_LOAD;
            reg_q   <= '0;
        end else if (accept) begin
            ea_lo_q <= ea_lo_c;
            ea_hi_q <= ea_hi_c;
            dir_q   <= cmd_store ? DIR_STORE : DIR_LOAD;
            reg_q   <= cmd_reg;
        end
    end

    dw_phase_mux #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_mux (
        .dir      (dir_q),
        .phase    (flags.phase),
        .pair_reg (reg_q),
        .ea_lo    (ea_lo_q),
        .ea_hi    (ea_hi_q),
        .acc_addr (mem_addr),
        .acc_reg  (acc_reg)
    );

    assign cmd_ready   = flags.idle;
    assign mem_req     = flags.access;
    assign mem_we      = flags.access && (dir_q == DIR_STORE);
    assign mem_wdata   = rf_rd_data;
    assign rf_rd_idx   = acc_reg;
    assign rf_wr_en    = flags.access && mem_ack && (dir_q == DIR_LOAD);
    assign rf_wr_idx   = acc_reg;
    assign rf_wr_data  = mem_rdata;
    assign done        = flags.fin;
    assign illegal     = flags.fault;
    assign ld_pend     = (flags.access || flags.fin) && (dir_q == DIR_LOAD);
    assign ld_pend_reg = reg_q;

    // R4: an outstanding request holds its address until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R1: requests are always word aligned
    p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0));
    // R5: an illegal command produces no traffic
    p_fault_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !rf_wr_en));
    // R7: ready and a request never coexist
    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req);
    // R8: a pending load never drives a write access
    p_pend_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pend |-> !mem_we);
    // R2: a register write is tied to an acknowledged request
    p_wr_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (mem_req && mem_ack));

endmodule

// File: tb/dw_pair_seq_bench.sv
`timescale 1ns/1ps
module dw_pair_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_store = 1'b0;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_disp = '0;
    logic [4:0]  cmd_reg = '0;
    logic        cmd_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [4:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        rf_wr_en;
    logic [4:0]  rf_wr_idx;
    logic [31:0] rf_wr_data;
    logic        done, illegal, ld_pend;
    logic [4:0]  ld_pend_reg;

    int checks = 0;
    int errors = 0;
    int mem_lat = 0;
    bit running = 0;

    typedef struct {
        bit          is_mem;
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [4:0]  idx;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] rf_model [32];
    assign rf_rd_data = rf_model[rf_rd_idx];

    dw_pair_seq u_dw_pair_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_base(cmd_base),
        .cmd_disp(cmd_disp), .cmd_reg(cmd_reg), .cmd_ready(cmd_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .done(done), .illegal(illegal), .ld_pend(ld_pend), .ld_pend_reg(ld_pend_reg)
    );

    initial forever #2 clk = ~clk;

    function automatic logic [31:0] rd_pat(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h3C00_00C3;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: one-cycle acknowledge after mem_lat idle cycles.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (cnt >= mem_lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = rd_pat(mem_addr);
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Monitor: pops the scoreboard as accesses and register writes appear.
    initial begin
        bit          prev_wait;
        bit          exp_done;
        logic [31:0] prev_addr;
        int          acks;
        exp_t        e;
        prev_wait = 0; exp_done = 0; prev_addr = '0; acks = 0;
        forever begin
            @(negedge clk); #1;
            if (running) begin
                if (done || exp_done)
                    check(done == exp_done, "R6", {31'd0, done}, {31'd0, exp_done}, "done timing");
                exp_done = 0;
                if (prev_wait)
                    check(mem_req && mem_addr == prev_addr, "R4", mem_addr, prev_addr, "request hold");
                if (mem_req && mem_ack) begin
                    if (exp_q.size() == 0 || !exp_q[0].is_mem) begin
                        check(0, "R7", mem_addr, 32'hFFFF_FFFF, "unexpected access");
                    end else begin
                        e = exp_q.pop_front();
                        check(mem_addr == e.addr, "R1", mem_addr, e.addr, "access address");
                        check(mem_we == e.we, e.tag, {31'd0, mem_we}, {31'd0, e.we}, "direction");
                        if (e.we)
                            check(mem_wdata == e.data, e.tag, mem_wdata, e.data, "store data");
                    end
                    acks++;
                    if (acks % 2 == 0) exp_done = 1;
                end
                if (rf_wr_en) begin
                    if (exp_q.size() == 0 || exp_q[0].is_mem) begin
                        check(0, "R2", {27'd0, rf_wr_idx}, 32'hFFFF_FFFF, "unexpected reg write");
                    end else begin
                        e = exp_q.pop_front();
                        check(rf_wr_idx == e.idx, e.tag, {27'd0, rf_wr_idx}, {27'd0, e.idx}, "write index");
                        check(rf_wr_data == e.data, e.tag, rf_wr_data, e.data, "write data");
                    end
                end
                prev_wait = mem_req && !mem_ack;
                prev_addr = mem_addr;
            end
        end
    end

    task automatic do_cmd(bit st, logic [31:0] base, logic [15:0] disp, logic [4:0] rg,
                          int lat, bit poke);
        logic [31:0] ea;
        logic [4:0]  odd;
        exp_t        e;
        int          cyc;
        bit          fin;
        ea  = (base + {{16{disp[15]}}, disp}) & 32'hFFFF_FFFC;
        odd = {rg[4:1], 1'b1};
        if (!rg[0]) begin
            if (!st) begin
                e = '{1, 0, ea,      32'd0,                0,   "R2"}; exp_q.push_back(e);
                e = '{0, 0, 32'd0,   rd_pat(ea),           odd, "R2"}; exp_q.push_back(e);
                e = '{1, 0, ea + 4,  32'd0,                0,   "R2"}; exp_q.push_back(e);
                e = '{0, 0, 32'd0,   rd_pat(ea + 4),       rg,  "R2"}; exp_q.push_back(e);
            end else begin
                e = '{1, 1, ea + 4,  rf_model[rg],         0,   "R3"}; exp_q.push_back(e);
                e = '{1, 1, ea,      rf_model[odd],        0,   "R3"}; exp_q.push_back(e);
            end
        end
        mem_lat = lat;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_store = st; cmd_base = base; cmd_disp = disp; cmd_reg = rg;
        #1;
        check(cmd_ready == 1'b1, "R7", {31'd0, cmd_ready}, 32'd1, "ready when idle");
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0; fin = 0;
        while (!fin && cyc < 200) begin
            #1;
            if (cyc == 1) cmd_valid = 1'b0;
            if (rg[0]) begin
                check(illegal == 1'b1, "R5", {31'd0, illegal}, 32'd1, "illegal pulse");
                check(mem_req == 1'b0, "R5", {31'd0, mem_req}, 32'd0, "no request on odd reg");
                check(ld_pend == 1'b0, "R8", {31'd0, ld_pend}, 32'd0, "no pend on odd reg");
                fin = 1;
            end else begin
                check(ld_pend == !st, "R8", {31'd0, ld_pend}, {31'd0, !st}, "pending flag");
                if (!st)
                    check(ld_pend_reg == rg, "R8", {27'd0, ld_pend_reg}, {27'd0, rg}, "pending reg");
                check(cmd_ready == 1'b0, "R7", {31'd0, cmd_ready}, 32'd0, "not ready while busy");
                if (poke && cyc == 0) begin
                    cmd_valid = 1'b1; cmd_store = 1'b1; cmd_reg = 5'd2; cmd_base = 32'h0000_8000;
                end
                if (done) fin = 1;
            end
            if (!fin) begin
                @(negedge clk);
                cyc++;
            end
        end
        cmd_valid = 1'b0;
        check(fin, "R6", 32'(cyc), 32'd0, "command completion");
        @(negedge clk); #1;
        check(done == 1'b0 && illegal == 1'b0, "R6", {30'd0, done, illegal}, 32'd0, "pulse width");
        check(ld_pend == 1'b0, "R8", {31'd0, ld_pend}, 32'd0, "pending cleared after slot");
        check(cmd_ready == 1'b1, "R7", {31'd0, cmd_ready}, 32'd1, "ready after command");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) rf_model[i] = 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
        repeat (3) @(negedge clk);
        #1;
        check(cmd_ready == 1'b1, "R9", {31'd0, cmd_ready}, 32'd1, "reset ready");
        check({mem_req, rf_wr_en, done, illegal, ld_pend} == 5'b0, "R9",
              {27'd0, mem_req, rf_wr_en, done, illegal, ld_pend}, 32'd0, "reset quiet");
        @(negedge clk);
        rst_n = 1'b1;
        running = 1;
        do_cmd(0, 32'h0000_1000, 16'h0010, 5'd4,  0, 0);  // R2 plain load
        do_cmd(0, 32'h0000_2000, 16'hFFF6, 5'd10, 2, 0);  // R1 negative displacement
        do_cmd(1, 32'h0000_3003, 16'h0002, 5'd6,  1, 0);  // R1 misaligned sum, R3 store
        do_cmd(1, 32'hFFFF_FFFC, 16'h0000, 5'd0,  3, 0);  // R1 wrap of EA+4
        do_cmd(0, 32'h0000_4000, 16'h0004, 5'd7,  0, 0);  // R5 odd register load
        do_cmd(1, 32'h0000_4000, 16'h0004, 5'd31, 0, 0);  // R5 odd register store
        do_cmd(0, 32'h0001_0000, 16'h7FFC, 5'd30, 3, 1);  // R7 command while busy
        do_cmd(1, 32'h8000_0000, 16'h8000, 5'd12, 2, 1);  // R7 busy poke on store
        do_cmd(0, 32'h1234_5678, 16'h0101, 5'd20, 1, 0);  // R4 latency on load
        repeat (4) @(negedge clk);
        #1;
        check(exp_q.size() == 0, "R7", 32'(exp_q.size()), 32'd0, "scoreboard drained");
        finish_run();
    end

endmodule